// File: doc/BRIEF.md
# Three-Wire Codec Control Bus Master

This block drives a three-line serial control bus (clock, data, mode) of the kind used to program audio codecs. A request names a 6-bit device, a 2-bit register bank, whether one or two data bytes follow, and whether the transfer writes or reads. The block then produces every edge of the transfer on its own. It starts with all lines high, sends an address byte with mode low, then sends one or two data bytes with mode high. A clock-low pause separates the first data byte from the second. On a read, the data line is released after the address byte and the returned bits are captured.

All waveform intervals are set as parameters counted in system clock cycles: clock low per bit, clock high per bit, setup before a byte, hold after a byte, and the pause before a second data byte. `busy` covers the whole transfer. `done` pulses once when the lines have returned to idle.

Top module: `ctl3w_master`

## Requirements
- R1: Out of reset and between transfers, bus_clk, bus_mode, bus_dat_o and bus_dat_oe are all 0, and busy and done are 0.
- R2: In the first cycle after a request is accepted, bus_clk, bus_mode, bus_dat_o and bus_dat_oe are all 1, for exactly one cycle.
- R3: Every bit holds bus_clk at 0 for T_LOW cycles and then at 1 for T_HIGH cycles. The data line only changes in the first cycle of the low part.
- R4: Each byte goes out least significant bit first, so bit i of a byte is driven in the i-th bit slot (i = 0..7).
- R5: The address byte is sent with bus_mode at 0. It is preceded by T_SETUP cycles with bus_clk at 0, and followed by T_HOLD cycles with bus_clk at 1.
- R6: Every data byte is sent with bus_mode at 1. It is preceded by T_SETUP cycles and followed by T_HOLD cycles, all with bus_clk at 1.
- R7: No pause precedes the first data byte. The second data byte is preceded by T_HALT cycles with bus_clk at 0 and bus_mode at 1.
- R8: The setup and hold windows keep the data line at its last driven value (or at 0 while released).
- R9: The address byte equals {req_dev, req_bank}: the device number in bits 7..2 and the bank selector in bits 1..0.
- R10: req_ext = 0 gives exactly one data byte (req_wd0); req_ext = 1 gives two (req_wd0, then req_wd1).
- R11: On a read (req_rd = 1), bus_dat_oe is 0 throughout the data bytes. bus_dat_i is sampled in the last low cycle of each bit. The first byte lands in rd_data[7:0] and the second in rd_data[15:8], bit i at bit i. Bytes not read, and all of rd_data after a write, are 0.
- R12: req_valid is accepted only while busy is 0; a request while busy is ignored. busy runs from the cycle after acceptance to the last hold cycle. done is high for exactly the one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_dev | input | 6 | Device number for the address byte |
| req_bank | input | 2 | Register bank selector for the address byte |
| req_ext | input | 1 | 1: two data bytes, 0: one |
| req_rd | input | 1 | 1: read the data bytes, 0: write them |
| req_wd0 | input | 8 | First data byte to write |
| req_wd1 | input | 8 | Second data byte to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at transfer end |
| rd_data | output | 16 | Bytes captured on a read |
| bus_clk | output | 1 | Bus clock line |
| bus_mode | output | 1 | Bus mode line |
| bus_dat_o | output | 1 | Data line output value |
| bus_dat_oe | output | 1 | Data line output enable |
| bus_dat_i | input | 1 | Data line input value |

## Verification
The assertions watch, on every cycle, properties that do not depend on the transfer content. Lines are quiet whenever busy is low. The start cycle has all lines high. The driven data never moves while the clock stays high. done is a single pulse that follows busy, and an idle request is always taken. Only the bench's reference model can show the exact interval lengths, the bit order, the address packing, the presence of the pause before the second byte, and the captured read value. It does this by replaying each request as an expected per-cycle waveform and comparing it against the design on every clock.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_SETUP,
    PH_BLO,
    PH_BHI,
    PH_HOLD,
    PH_HALT
  } ph_e;

  function automatic int max_of5(input int a, input int b, input int c,
                                 input int d, input int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/ctl3w_rstsync.sv
module ctl3w_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ctl3w_timer.sv
module ctl3w_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/ctl3w_rxcap.sv
module ctl3w_rxcap #(
  parameter int NB = 2,
  parameter int BW = 8,
  localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1,
  localparam int BIT_W = (BW > 1) ? $clog2(BW) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cap,
  input  logic [SEL_W-1:0] byte_sel,
  input  logic [BIT_W-1:0] bit_sel,
  input  logic             din,
  output logic [NB*BW-1:0] data
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [BW-1:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       byte_q <= '0;
      else if (clr)                                     byte_q <= '0;
      else if (cap && (byte_sel == SEL_W'(g)))          byte_q[bit_sel] <= din;
    end
    assign data[g*BW +: BW] = byte_q;
  end
endmodule

// File: rtl/ctl3w_master.sv
module ctl3w_master
  import ctl3w_pkg::*;
#(
  parameter int T_LOW   = 3,
  parameter int T_HIGH  = 2,
  parameter int T_SETUP = 2,
  parameter int T_HOLD  = 2,
  parameter int T_HALT  = 4,
  parameter int DEV_W   = 6,
  parameter int BANK_W  = 2,
  localparam int BW     = DEV_W + BANK_W,
  localparam int NB     = 2,
  localparam int TMAX   = max_of5(T_LOW, T_HIGH, T_SETUP, T_HOLD, T_HALT),
  localparam int CNT_W  = (TMAX > 1) ? $clog2(TMAX) : 1,
  localparam int BIT_W  = $clog2(BW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [BANK_W-1:0] req_bank,
  input  logic              req_ext,
  input  logic              req_rd,
  input  logic [BW-1:0]     req_wd0,
  input  logic [BW-1:0]     req_wd1,
  output logic              busy,
  output logic              done,
  output logic [NB*BW-1:0]  rd_data,
  output logic              bus_clk,
  output logic              bus_mode,
  output logic              bus_dat_o,
  output logic              bus_dat_oe,
  input  logic              bus_dat_i
);

  logic rst_sync_n;

  ph_e             ph_q, ph_d;
  logic [1:0]      byte_q, byte_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic            dat_q, dat_d;
  logic            done_q, done_d;
  logic [BW-1:0]   addr_q, wd0_q, wd1_q;
  logic            ext_q, rd_q;

  logic            accept, drive, tmr_zero, tmr_load, cap_en;
  logic [CNT_W-1:0] tmr_val;
  logic [BW-1:0]   cur_byte;
  logic [1:0]      last_byte;
  logic [BIT_W-1:0] bit_nxt;

  ctl3w_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ctl3w_timer #(.W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  ctl3w_rxcap #(.NB(NB), .BW(BW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (accept),
    .cap      (cap_en),
    .byte_sel (1'(byte_q - 2'd1)),
    .bit_sel  (bit_q),
    .din      (bus_dat_i),
    .data     (rd_data)
  );

  assign accept    = req_valid && (ph_q == PH_IDLE);
  assign drive     = (byte_q == 2'd0) || !rd_q;
  assign last_byte = ext_q ? 2'd2 : 2'd1;
  assign bit_nxt   = bit_q + 1'b1;

  always_comb begin
    case (byte_q)
      2'd0:    cur_byte = addr_q;
      2'd1:    cur_byte = wd0_q;
      default: cur_byte = wd1_q;
    endcase
  end

  // next-state logic
  always_comb begin
    ph_d     = ph_q;
    byte_d   = byte_q;
    bit_d    = bit_q;
    dat_d    = dat_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_en   = 1'b0;
    case (ph_q)
      PH_IDLE: if (accept) begin
        ph_d     = PH_START;
        byte_d   = 2'd0;
        dat_d    = 1'b1;
        tmr_load = 1'b1;
      end
      PH_START: if (tmr_zero) begin
        ph_d     = PH_SETUP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_SETUP - 1);
      end
      PH_SETUP: if (tmr_zero) begin
        ph_d     = PH_BLO;
        bit_d    = '0;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_LOW - 1);
        if (drive) dat_d = cur_byte[0];
      end
      PH_BLO: if (tmr_zero) begin
        ph_d     = PH_BHI;
        cap_en   = !drive;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_HIGH - 1);
      end
      PH_BHI: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (bit_q == BIT_W'(BW - 1)) begin
          ph_d    = PH_HOLD;
          tmr_val = CNT_W'(T_HOLD - 1);
        end else begin
          ph_d    = PH_BLO;
          bit_d   = bit_nxt;
          tmr_val = CNT_W'(T_LOW - 1);
          if (drive) dat_d = cur_byte[bit_nxt];
        end
      end
      PH_HOLD: if (tmr_zero) begin
        if (byte_q == last_byte) begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end else begin
          byte_d   = byte_q + 2'd1;
          tmr_load = 1'b1;
          if (byte_q == 2'd1) begin
            ph_d    = PH_HALT;
            tmr_val = CNT_W'(T_HALT - 1);
          end else begin
            ph_d    = PH_SETUP;
            tmr_val = CNT_W'(T_SETUP - 1);
          end
        end
      end
      PH_HALT: if (tmr_zero) begin
        ph_d     = PH_SETUP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_SETUP - 1);
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ph_q   <= PH_IDLE;
      byte_q <= 2'd0;
      bit_q  <= '0;
      dat_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      byte_q <= byte_d;
      bit_q  <= bit_d;
      dat_q  <= dat_d;
      done_q <= done_d;
    end
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q <= '0;
      wd0_q  <= '0;
      wd1_q  <= '0;
      ext_q  <= 1'b0;
      rd_q   <= 1'b0;
    end else if (accept) begin
      addr_q <= {req_dev, req_bank};
      wd0_q  <= req_wd0;
      wd1_q  <= req_wd1;
      ext_q  <= req_ext;
      rd_q   <= req_rd;
    end
  end

  // line decode
  always_comb begin
    bus_clk    = 1'b0;
    bus_mode   = 1'b0;
    bus_dat_oe = 1'b0;
    case (ph_q)
      PH_IDLE:  ;
      PH_START: begin bus_clk = 1'b1; bus_mode = 1'b1; bus_dat_oe = 1'b1; end
      PH_SETUP: begin bus_clk = (byte_q != 2'd0); bus_mode = (byte_q != 2'd0); bus_dat_oe = drive; end
      PH_BLO,
      PH_HALT:  begin bus_clk = 1'b0; bus_mode = (byte_q != 2'd0); bus_dat_oe = drive; end
      default:  begin bus_clk = 1'b1; bus_mode = (byte_q != 2'd0); bus_dat_oe = drive; end
    endcase
  end

  assign bus_dat_o = bus_dat_oe & dat_q;
  assign busy      = (ph_q != PH_IDLE);
  assign done      = done_q;

endmodule

// File: rtl/ctl3w_checker.sv
module ctl3w_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic bus_clk,
  input logic bus_mode,
  input logic bus_dat_o,
  input logic bus_dat_oe
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_clk && !bus_mode && !bus_dat_oe && !bus_dat_o));

  p_start_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bus_clk && bus_mode && bus_dat_o && bus_dat_oe));

  p_data_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_clk && bus_dat_oe && $past(busy) && $past(bus_clk) && $past(bus_dat_oe))
      |-> $stable(bus_dat_o));

  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_follows_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_idle_accepts_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

endmodule

bind ctl3w_master ctl3w_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .busy       (busy),
  .done       (done),
  .bus_clk    (bus_clk),
  .bus_mode   (bus_mode),
  .bus_dat_o  (bus_dat_o),
  .bus_dat_oe (bus_dat_oe)
);

// File: tb/ctl3w_master_test.sv
module ctl3w_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int TL = 3, TH = 2, TS = 2, THD = 2, THA = 4;
  localparam int WATCHDOG = 20000;

  logic        clk, rst_n;
  logic        req_valid, req_ext, req_rd;
  logic [5:0]  req_dev;
  logic [1:0]  req_bank;
  logic [7:0]  req_wd0, req_wd1;
  logic        busy, done, bus_clk, bus_mode, bus_dat_o, bus_dat_oe, bus_dat_i;
  logic [15:0] rd_data;
  logic [15:0] resp;

  int checks = 0, errors = 0, accepts = 0, dones = 0, cycles = 0;

  // expected-cycle word: [0]clk [1]mode [2]dat [3]oe [4]busy [5]done
  // [6]din [7]check rd [11:8]tag [27:12]rd expected
  logic [31:0] q[$];

  ctl3w_master #(.T_LOW(TL), .T_HIGH(TH), .T_SETUP(TS), .T_HOLD(THD), .T_HALT(THA)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dev(req_dev),
    .req_bank(req_bank), .req_ext(req_ext), .req_rd(req_rd), .req_wd0(req_wd0),
    .req_wd1(req_wd1), .busy(busy), .done(done), .rd_data(rd_data),
    .bus_clk(bus_clk), .bus_mode(bus_mode), .bus_dat_o(bus_dat_o),
    .bus_dat_oe(bus_dat_oe), .bus_dat_i(bus_dat_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd7: return "R7";
      4'd8: return "R8";   4'd9: return "R9";   4'd10: return "R10";
      4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic add(input int n, input bit c, input bit m, input bit d, input bit oe,
                     input bit din, input int tag);
    for (int k = 0; k < n; k++)
      q.push_back({4'd0, 16'd0, 4'(tag), 1'b0, din, 1'b0, 1'b1, oe, d, m, c});
  endtask

  task automatic build(input logic [5:0] dev, input logic [1:0] bank, input bit ext,
                       input bit rd, input logic [7:0] w0, input logic [7:0] w1,
                       input logic [15:0] rsp);
    logic [7:0] val;
    logic [15:0] rexp;
    bit last, drv, md;
    int nb;
    nb = ext ? 2 : 1;
    last = 1'b1;
    add(1, 1, 1, 1, 1, 0, 2);
    for (int b = 0; b <= nb; b++) begin
      val = (b == 0) ? {dev, bank} : (b == 1 ? w0 : w1);
      drv = (b == 0) || !rd;
      md  = (b != 0);
      if (b == 2) add(THA, 0, 1, drv ? last : 1'b0, drv, 0, 7);
      add(TS, md, md, drv ? last : 1'b0, drv, 0, (b == 0) ? 5 : 8);
      for (int i = 0; i < 8; i++) begin
        bit din;
        din = drv ? 1'b0 : rsp[(b-1)*8 + i];
        if (drv) last = val[i];
        add(TL, 0, md, drv ? last : 1'b0, drv, din, (b == 0) ? 9 : (!drv ? 11 : (b == 2 ? 10 : 4)));
        add(TH, 1, md, drv ? last : 1'b0, drv, din, 3);
      end
      add(THD, 1, md, drv ? last : 1'b0, drv, 0, (b == 0) ? 5 : 8);
    end
    rexp = !rd ? 16'h0 : (ext ? rsp : {8'h00, rsp[7:0]});
    q.push_back({4'd0, rexp, 4'd12, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0000});
  endtask

  // reference model advances on every rising edge
  always @(posedge clk) begin
    bit cur_busy;
    if (!rst_n) q.delete();
    else begin
      cur_busy = (q.size() != 0) && q[0][4];
      if (q.size() != 0) void'(q.pop_front());
      if (req_valid && !cur_busy) begin
        accepts++;
        build(req_dev, req_bank, req_ext, req_rd, req_wd0, req_wd1, resp);
      end
    end
  end

  task automatic fail(input string tag, input string what, input logic [15:0] act,
                      input logic [15:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cycles);
  endtask

  // compare away from the active edge and drive the responder
  always @(negedge clk) begin
    logic [31:0] e;
    if (rst_n) begin
      cycles++;
      e = (q.size() != 0) ? q[0] : 32'h0000_0100;
      bus_dat_i <= e[6];
      checks++;
      if (bus_clk   !== e[0]) fail(tag_name(e[11:8]), "bus_clk", 16'(bus_clk), 16'(e[0]));
      if (bus_mode  !== e[1]) fail("R5 R6", "bus_mode", 16'(bus_mode), 16'(e[1]));
      if (bus_dat_o !== e[2]) fail(tag_name(e[11:8]), "bus_dat_o", 16'(bus_dat_o), 16'(e[2]));
      if (bus_dat_oe !== e[3]) fail("R11", "bus_dat_oe", 16'(bus_dat_oe), 16'(e[3]));
      if (busy      !== e[4]) fail("R12", "busy", 16'(busy), 16'(e[4]));
      if (done      !== e[5]) fail("R12", "done", 16'(done), 16'(e[5]));
      if (e[7] && rd_data !== e[27:12]) fail("R11", "rd_data", rd_data, e[27:12]);
      if (done === 1'b1) dones++;
    end else bus_dat_i <= 1'b0;
  end

  task automatic request(input logic [5:0] dev, input logic [1:0] bank, input bit ext,
                         input bit rd, input logic [7:0] w0, input logic [7:0] w1,
                         input logic [15:0] rsp);
    @(negedge clk);
    req_valid = 1'b1; req_dev = dev; req_bank = bank; req_ext = ext; req_rd = rd;
    req_wd0 = w0; req_wd1 = w1; resp = rsp;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int d0;
    req_valid = 0; req_dev = 0; req_bank = 0; req_ext = 0; req_rd = 0;
    req_wd0 = 0; req_wd1 = 0; resp = 0; bus_dat_i = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({bus_clk, bus_mode, bus_dat_oe, busy, done} !== 5'b0)
      fail("R1", "reset lines", 16'({bus_clk, bus_mode, bus_dat_oe, busy, done}), 16'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9 R4 R10: direct write, single data byte
    request(6'h05, 2'd2, 0, 0, 8'hA5, 8'h00, 16'h0);  wait_idle();
    // R7 R10: extended write, pause before second byte
    request(6'h2A, 2'd1, 1, 0, 8'hC3, 8'h5E, 16'h0);  wait_idle();
    // R11: single-byte read
    request(6'h13, 2'd3, 0, 1, 8'h00, 8'h00, 16'hFF6B); wait_idle();
    // R11: two-byte read
    request(6'h3F, 2'd0, 1, 1, 8'h00, 8'h00, 16'h9A3C); wait_idle();

    // R12: request while busy is ignored
    d0 = dones;
    request(6'h01, 2'd0, 0, 0, 8'h81, 8'h00, 16'h0);
    repeat (10) @(negedge clk);
    request(6'h3E, 2'd3, 1, 0, 8'hFF, 8'hFF, 16'h0);
    wait_idle();
    checks++;
    if (dones - d0 != 1) fail("R12", "done count after ignored request", 16'(dones - d0), 16'd1);

    // R12: request held through the done cycle starts the next transfer at once
    d0 = accepts;
    @(negedge clk);
    req_valid = 1'b1; req_dev = 6'h22; req_bank = 2'd1; req_ext = 1'b1; req_rd = 1'b0;
    req_wd0 = 8'h0F; req_wd1 = 8'hF0; resp = 16'h0;
    while (accepts - d0 < 2) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    checks++;
    if (accepts - d0 != 2) fail("R12", "back-to-back accepts", 16'(accepts - d0), 16'd2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule